// File: doc/BRIEF.md
# Fixed-Function Event Counter Bank

This block counts memory-controller activity for performance monitoring. It holds eight 32-bit counters, and each one is permanently bound to one event input: counter i counts pulses on `evt_pulse[i]`. The eight events are write data beats, read data beats, write commands, read commands, precharges, activates, rank switches and read/write turnarounds. No event-select field exists, so the counter index is the event code.

Software reaches the bank through a simple register port: a single-cycle write strobe with address and data, and a combinational read path. One control bit gates every counter. A per-counter enable byte picks which counters run. When a counter wraps past its top value, a sticky status bit is set, and that bit can raise an interrupt unless it is masked. Software can preload any counter with a start value, so it can arrange for an interrupt after a chosen number of events.

Top module: `fixed_evt_bank`

## Requirements
- R1: After reset, every counter, the global enable, the per-counter enables and the status bits read as zero, the mask reads 0xFF and `irq` is low.
- R2: Counter i is at 0x380+4*i for i in 0..3 and at 0x3C0+4*(i-4) for i in 4..7. It adds one on each clock edge where `evt_pulse[i]` is high while the bank is running and counter i is enabled. The new value is readable right after that edge.
- R3: The global enable is bit 1 of the control register at 0x010. Writing bit 0 or any other bit does not start counting. Reading returns only bit 1, with all other bits zero.
- R4: Bits [7:0] of the register at 0x6C0 enable counters 7..0 one bit each. A counter whose bit is 0 holds its value even when its event fires.
- R5: A write to a counter's address loads the write data into it. A write in the same cycle as that counter's event takes priority, and the counter then holds exactly the written value.
- R6: A running counter at 0xFFFFFFFF that sees an event becomes 0 and keeps counting after that. The wrap sets bit i of the status register at 0x6CC.
- R7: Writing 1 to bit i at 0x6D0 clears status bit i, and 0 bits leave the status as it is. If a wrap of counter i happens in the same cycle as the clear, status bit i stays set. Reads of 0x6D0 return zero.
- R8: The mask register at 0x6C8 has one bit per counter, where 1 masks and 0 unmasks. `irq` is high exactly while some status bit is set whose mask bit is 0.
- R9: Writes to addresses other than those above change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 12 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_pulse | input | 8 | Event pulses; bit i feeds counter i |
| irq | output | 1 | Level interrupt for an unmasked wrap |

## Verification
Each result appears after exactly one register stage. An event, a counter load, a register write, a status clear and a wrap all become visible in the first read after the clock edge that samples them. `irq` follows the status and mask in that same cycle, with no additional delay. The bench advances a behavioural model on the same edge. It drives inputs and compares the read data and `irq` only at the falling edge, so every comparison sees the state one edge after the stimulus. Directed peeks at that falling edge check the corner cases: a load that collides with an event, a wrap, and a clear that collides with a wrap.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int NUM_CTR     = 8;
  localparam int ADDR_W      = 12;
  localparam int CTRL_EN_BIT = 1;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_EN   = 12'h6C0;
  localparam logic [ADDR_W-1:0] OFF_MASK = 12'h6C8;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h6CC;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 12'h6D0;

  // counters sit in two groups of four words
  function automatic logic [ADDR_W-1:0] ctr_offset(input int idx);
    if (idx < 4) return 12'h380 + ADDR_W'(idx * 4);
    else         return 12'h3C0 + ADDR_W'((idx - 4) * 4);
  endfunction
endpackage

// File: rtl/evb_counter.sv
module evb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] count,
  output logic         wrap
);
  function automatic logic [W:0] bump(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W:0] nxt;
  assign nxt  = bump(count);
  assign wrap = run && !load && nxt[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (run)  count <= nxt[W-1:0];
  end

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> count == ($past(count) + 1'b1));
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
endmodule

// File: rtl/evb_ctrl.sv
module evb_ctrl
  import evb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_CTR-1:0] wbits,
  output logic               glb_en,
  output logic [NUM_CTR-1:0] ctr_en,
  output logic [NUM_CTR-1:0] irq_mask,
  output logic [NUM_CTR-1:0] clr_bits
);
  assign clr_bits = (wr_en && addr == OFF_CLR) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      ctr_en   <= '0;
      irq_mask <= '1;
    end else if (wr_en) begin
      if (addr == OFF_CTRL) glb_en   <= wbits[CTRL_EN_BIT];
      if (addr == OFF_EN)   ctr_en   <= wbits;
      if (addr == OFF_MASK) irq_mask <= wbits;
    end
  end

  a_r3_glb_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CTRL) |=> glb_en == $past(wbits[CTRL_EN_BIT]));
  a_r8_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MASK) |=> irq_mask == $past(wbits));
endmodule

// File: rtl/evb_irq.sv
module evb_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap_vec,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] live;
  assign live = status & ~mask;
  assign irq  = |live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_bits) | wrap_vec;
  end

  a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((status & $past(wrap_vec)) == $past(wrap_vec)));
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_bits & ~wrap_vec)) |=> ((status & $past(clr_bits & ~wrap_vec)) == '0));
  a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);
endmodule

// File: rtl/fixed_evt_bank.sv
module fixed_evt_bank
  import evb_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CTR_W-1:0]   reg_wdata,
  output logic [CTR_W-1:0]   reg_rdata,
  input  logic [NUM_CTR-1:0] evt_pulse,
  output logic               irq
);
  logic               glb_en;
  logic [NUM_CTR-1:0] ctr_en, irq_mask, clr_bits, status, wrap_vec, load_vec, run_vec;
  logic [CTR_W-1:0]   cnt [NUM_CTR];

  evb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wbits(reg_wdata[NUM_CTR-1:0]), .glb_en(glb_en), .ctr_en(ctr_en),
    .irq_mask(irq_mask), .clr_bits(clr_bits)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign load_vec[i] = reg_wr && (reg_addr == ctr_offset(i));
    assign run_vec[i]  = glb_en && ctr_en[i] && evt_pulse[i];
    evb_counter #(.W(CTR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load_vec[i]), .load_val(reg_wdata),
      .run(run_vec[i]), .count(cnt[i]), .wrap(wrap_vec[i])
    );
  end

  evb_irq #(.N(NUM_CTR)) u_irq (
    .clk(clk), .rst_n(rst_n), .wrap_vec(wrap_vec), .clr_bits(clr_bits),
    .mask(irq_mask), .status(status), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_CTRL) reg_rdata[CTRL_EN_BIT] = glb_en;
    if (reg_addr == OFF_EN)   reg_rdata[NUM_CTR-1:0] = ctr_en;
    if (reg_addr == OFF_MASK) reg_rdata[NUM_CTR-1:0] = irq_mask;
    if (reg_addr == OFF_STAT) reg_rdata[NUM_CTR-1:0] = status;
    for (int i = 0; i < NUM_CTR; i++)
      if (reg_addr == ctr_offset(i)) reg_rdata = cnt[i];
  end

  a_r1_loads_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));
  a_r3_stopped_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> wrap_vec == '0);
endmodule

// File: tb/fixed_evt_bank_tb.sv
module fixed_evt_bank_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  evt = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_cnt [8];
  logic        m_glb;
  logic [7:0]  m_en, m_mask, m_stat;
  logic [15:0] lf = 16'hACE1;
  logic        cmp_on = 1'b0;

  fixed_evt_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .evt_pulse(evt), .irq(irq)
  );

  function automatic int idx_of(input logic [11:0] a);
    case (a)
      12'h380: return 0; 12'h384: return 1; 12'h388: return 2; 12'h38C: return 3;
      12'h3C0: return 4; 12'h3C4: return 5; 12'h3C8: return 6; 12'h3CC: return 7;
      default: return -1;
    endcase
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_glb = 0; m_en = 0; m_mask = 8'hFF; m_stat = 0;
    end else begin
      logic [7:0] wraps;
      wraps = 0;
      for (int k = 0; k < 8; k++) begin
        if (wr && idx_of(addr) == k) m_cnt[k] = wdata;
        else if (m_glb && m_en[k] && evt[k]) begin
          if (m_cnt[k] == 32'hFFFF_FFFF) wraps[k] = 1'b1;
          m_cnt[k] = m_cnt[k] + 1;
        end
      end
      if (wr && addr == 12'h6D0) m_stat = m_stat & ~wdata[7:0];
      m_stat = m_stat | wraps;
      if (wr && addr == 12'h010) m_glb  = wdata[1];
      if (wr && addr == 12'h6C0) m_en   = wdata[7:0];
      if (wr && addr == 12'h6C8) m_mask = wdata[7:0];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (idx_of(a) >= 0) return m_cnt[idx_of(a)];
    case (a)
      12'h010: return {30'b0, m_glb, 1'b0};
      12'h6C0: return {24'b0, m_en};
      12'h6C8: return {24'b0, m_mask};
      12'h6CC: return {24'b0, m_stat};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (idx_of(a) >= 0) return "R2 counter read";
    case (a)
      12'h010: return "R3 control read";
      12'h6C0: return "R4 enable read";
      12'h6C8: return "R8 mask read";
      12'h6CC: return "R6 status read";
      12'h6D0: return "R7 clear reads zero";
      default: return "R9 unmapped read";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    if (cmp_on) begin
      chk(tag_of(addr), rdata, exp_rd(addr));
      chk("R8 irq level", {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
    end
    wr = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic peek(input logic [11:0] a, input string tag, input logic [31:0] exp);
    step(1'b0, a, 32'b0, 8'b0);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(12'h010, "R1 control after reset", 32'h0);
    cmp_on = 1'b1;
    peek(12'h6C0, "R1 enable after reset", 32'h0);
    peek(12'h6C8, "R1 mask after reset", 32'hFF);
    peek(12'h6CC, "R1 status after reset", 32'h0);
    peek(12'h3CC, "R1 counter7 after reset", 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R3: bit 0 does not start counting
    step(1'b1, 12'h6C0, 32'hFF, 8'h00);
    step(1'b1, 12'h010, 32'h1, 8'h00);
    repeat (3) step(1'b0, 12'h380, 32'h0, 8'hFF);
    peek(12'h380, "R3 bit0 alone keeps counter0 idle", 32'h0);
    peek(12'h010, "R3 bit0 reads as zero", 32'h0);

    // R4: only low four counters enabled
    step(1'b1, 12'h010, 32'h2, 8'h00);
    step(1'b1, 12'h6C0, 32'h0F, 8'h00);
    repeat (4) step(1'b0, 12'h384, 32'h0, 8'hFF);
    peek(12'h380, "R2 counter0 counted four", 32'd4);
    peek(12'h3C0, "R4 disabled counter4 held", 32'h0);
    peek(12'h010, "R3 bit1 reads back", 32'h2);

    // R2 random traffic with rotating reads
    step(1'b1, 12'h6C0, 32'hFF, 8'h00);
    for (int n = 0; n < 400; n++) begin
      logic [11:0] ra;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (n % 6)
        0: ra = 12'h380 + 12'(4 * (n % 4));
        1: ra = 12'h3C0 + 12'(4 * (n % 4));
        2: ra = 12'h6CC;
        3: ra = 12'h6C0;
        4: ra = 12'h388;
        default: ra = 12'h3C8;
      endcase
      step(1'b0, ra, 32'h0, lf[7:0]);
    end

    // R5: load collides with event
    step(1'b1, 12'h38C, 32'hFFFF_FFFE, 8'h08);
    peek(12'h38C, "R5 load beats same-cycle event", 32'hFFFF_FFFE);
    // R6 wrap
    step(1'b0, 12'h38C, 32'h0, 8'h08);
    step(1'b0, 12'h38C, 32'h0, 8'h08);
    peek(12'h38C, "R6 counter3 wrapped to zero", 32'h0);
    peek(12'h6CC, "R6 status bit3 set", 32'h08);
    chk("R8 masked wrap keeps irq low", {31'b0, irq}, 32'h0);
    step(1'b1, 12'h6C8, 32'hF7, 8'h00);
    peek(12'h6CC, "R8 unmask", 32'h08);
    chk("R8 irq rises when unmasked", {31'b0, irq}, 32'h1);
    step(1'b0, 12'h38C, 32'h0, 8'h08);
    peek(12'h38C, "R6 keeps counting after wrap", 32'h1);

    // R7 clear
    step(1'b1, 12'h6D0, 32'h0, 8'h00);
    peek(12'h6CC, "R7 zero clear has no effect", 32'h08);
    step(1'b1, 12'h6D0, 32'h08, 8'h00);
    peek(12'h6CC, "R7 clear bit3", 32'h0);
    chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
    peek(12'h6D0, "R7 clear register reads zero", 32'h0);
    step(1'b1, 12'h3C4, 32'hFFFF_FFFF, 8'h00);
    step(1'b1, 12'h6D0, 32'h20, 8'h20);
    peek(12'h6CC, "R7 wrap beats same-cycle clear", 32'h20);

    // R9 unmapped
    step(1'b1, 12'h390, 32'h1234, 8'h00);
    step(1'b1, 12'h6C4, 32'hFF, 8'h00);
    peek(12'h390, "R9 unmapped reads zero", 32'h0);
    peek(12'h6C8, "R9 mask untouched by unmapped write", 32'hF7);
    step(1'b0, 12'h010, 32'h0, 8'h00);
    step(1'b0, 12'h010, 32'h0, 8'h00);
    finish_run();
  end
endmodule